// File: doc/BRIEF.md
# Token-Ring Node Event and Diagnostic Flags

This block gathers the event flags of a node on a token-passing network and presents them as two 8-bit bytes. The status byte carries transmitter and reconfiguration state. The diagnostic byte carries fault and activity indications that software reads when it investigates ring problems. Each flag has its own set source and its own clear source: a command, a read of the diagnostic byte, or the power-on clear command alone. When a set and a clear reach a flag in the same cycle, the set wins.

Two small engines feed the flags. A line-idle timer watches the receive input and reports a ring reconfiguration when the line stays at logic 0 for a parameterised number of clock cycles. A negative-acknowledge counter reports excessive refusals once a selectable low or high count has been reached. Three flags, each gated by its own mask bit, are ORed into a single registered interrupt line.

Event strobes, command strobes and the read strobe are single-cycle, active-high inputs that are synchronous to `clk`.

Top module: `netdiag_status`

## Requirements
- R1: After reset, `stat_byte` is 0x01 (only the transmitter-available flag is set), `diag_byte` is 0x00 and `irq` is 0.
- R2: Bit 2 of `stat_byte` (reconfiguration) sets on the clock edge that ends IDLE_CYCLES consecutive sampled cycles with `rx_line` at 0. Any sampled 1 restarts the count from zero, and the timer starts counting again after it fires.
- R3: The reconfiguration flag and the diagnostic flags in bits 7, 5 and 4 are cleared only by `cmd_clr_flags` or `cmd_por_clr`. `rd_diag` leaves them unchanged.
- R4: Bit 0 of `stat_byte` (transmitter available) sets on `evt_last_byte` or on `cmd_tx_dis`.
- R5: `cmd_tx_en` clears bit 1 of `stat_byte` (acknowledged) at the next edge. It also arms a pending state, and bit 0 then clears at the first later `evt_token_rx` whose two destination bytes both equal `node_id`. `cmd_tx_dis` cancels the pending state.
- R6: Bit 1 of `stat_byte` sets on `evt_ack` while `ack_bcast` is 0. An `evt_ack` with `ack_bcast` at 1 never sets it.
- R7: The `diag_byte` layout is: bit 7 lost-token (set by `evt_lost_token`), bit 6 duplicate-ID, bit 5 receive activity (set whenever `rx_line` is sampled at 1), bit 4 foreign token (set by `evt_token_other`), bit 3 excessive NAK. Bits 2..0 read 0.
- R8: Bit 6 of `diag_byte` sets on `evt_response` when the most recent `evt_token_rx` had both destination bytes equal to `node_id`. It clears at the edge after an `rd_diag` strobe.
- R9: Bit 3 of `diag_byte` sets on the NAK_THR_LO-th `evt_nak` when `nak_sel` is 0, or on the NAK_THR_HI-th when `nak_sel` is 1. Only `cmd_por_clr` clears it, and that command also resets the NAK count to zero.
- R10: `irq` is registered: one cycle after the flags and mask it equals (TA & `irq_mask[0]`) | (reconfiguration & `irq_mask[1]`) | (excessive NAK & `irq_mask[2]`).
- R11: When a set event and a clear event hit the same flag in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Synchronised receive line level |
| evt_last_byte | input | 1 | Last byte of the scheduled packet sent |
| evt_ack | input | 1 | Transmitted packet acknowledged |
| ack_bcast | input | 1 | Packet being acknowledged is a broadcast |
| evt_token_rx | input | 1 | Token frame observed, destination bytes valid |
| tok_dst_a | input | ID_W | First destination byte of the token |
| tok_dst_b | input | ID_W | Second destination byte of the token |
| node_id | input | ID_W | Node identifier |
| evt_response | input | 1 | Response to the last token detected |
| evt_token_other | input | 1 | Token sent by another node observed |
| evt_lost_token | input | 1 | Lost-token timer expired |
| evt_nak | input | 1 | NAK received for a free-buffer enquiry |
| nak_sel | input | 1 | 0: low NAK threshold, 1: high NAK threshold |
| cmd_tx_en | input | 1 | Enable-transmit command |
| cmd_tx_dis | input | 1 | Disable-transmitter command |
| cmd_clr_flags | input | 1 | Clear-flags command |
| cmd_por_clr | input | 1 | Power-on clear-flags command |
| rd_diag | input | 1 | Read strobe of the diagnostic byte |
| irq_mask | input | 3 | Interrupt mask: bit 0 TA, bit 1 reconfiguration, bit 2 excessive NAK |
| stat_byte | output | 8 | Status byte |
| diag_byte | output | 8 | Diagnostic byte |
| irq | output | 1 | Registered interrupt |

## Verification
The bench builds the block with IDLE_CYCLES set to 24 and keeps the NAK thresholds at 4 and 128. At that idle length the random stimulus holds the line low long enough to fire the timer several times. It also lets directed cases land exactly one cycle either side of the timeout. Keeping the real thresholds means both the low and the high NAK counts are driven to their boundary, and the sticky behaviour across reads and the counter restart after the power-on clear are both exercised.

// File: rtl/netdiag_pkg.sv
package netdiag_pkg;
   // status byte bit positions
   localparam int STAT_TA    = 0;
   localparam int STAT_TMA   = 1;
   localparam int STAT_RECON = 2;
   // diagnostic byte bit positions
   localparam int DIAG_LOST  = 7;
   localparam int DIAG_DUP   = 6;
   localparam int DIAG_RXACT = 5;
   localparam int DIAG_TOK   = 4;
   localparam int DIAG_XNAK  = 3;
   // interrupt mask bit positions
   localparam int MSK_TA     = 0;
   localparam int MSK_RECON  = 1;
   localparam int MSK_XNAK   = 2;
   localparam int MSK_W      = 3;
endpackage

// File: rtl/netdiag_flag.sv
module netdiag_flag #(
   parameter bit RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic q_o
);
   always_ff @(posedge clk) begin
      if (!rst_n)     q_o <= RST_VAL;
      else if (set_i) q_o <= 1'b1;
      else if (clr_i) q_o <= 1'b0;
   end

   assert_set_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> q_o);
endmodule

// File: rtl/netdiag_idle_timer.sv
module netdiag_idle_timer #(
   parameter int IDLE_CYCLES = 65600
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rx_line,
   output logic timeout_o
);
   localparam int CW = (IDLE_CYCLES > 1) ? $clog2(IDLE_CYCLES) : 1;
   localparam logic [CW-1:0] LAST = CW'(IDLE_CYCLES - 1);

   generate
      if (IDLE_CYCLES < 2) begin : g_bad
         $error("IDLE_CYCLES must be at least 2");
      end
   endgenerate

   logic [CW-1:0] cnt;

   assign timeout_o = !rx_line && (cnt == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n || rx_line || timeout_o) cnt <= '0;
      else                                cnt <= cnt + 1'b1;
   end

   assert_idle_restart_R2: assert property (@(posedge clk) disable iff (!rst_n)
      rx_line |=> (cnt == '0));
endmodule

// File: rtl/netdiag_nak_counter.sv
module netdiag_nak_counter #(
   parameter int NAK_THR_LO = 4,
   parameter int NAK_THR_HI = 128
) (
   input  logic clk,
   input  logic rst_n,
   input  logic nak_i,
   input  logic sel_hi_i,
   input  logic clr_i,
   output logic hit_o
);
   localparam int CW = $clog2(NAK_THR_HI + 1);
   localparam logic [CW-1:0] LO_LAST = CW'(NAK_THR_LO - 1);
   localparam logic [CW-1:0] HI_LAST = CW'(NAK_THR_HI - 1);
   localparam logic [CW-1:0] SAT     = CW'(NAK_THR_HI);

   generate
      if (NAK_THR_LO < 1 || NAK_THR_HI < NAK_THR_LO) begin : g_bad
         $error("NAK thresholds must satisfy 1 <= LO <= HI");
      end
   endgenerate

   logic [CW-1:0] cnt;
   logic          at_last;

   generate
      if (NAK_THR_LO == NAK_THR_HI) begin : g_single
         assign at_last = (cnt == HI_LAST);
         logic unused_sel;
         assign unused_sel = sel_hi_i;
      end else begin : g_dual
         assign at_last = sel_hi_i ? (cnt == HI_LAST) : (cnt == LO_LAST);
      end
   endgenerate

   assign hit_o = nak_i && at_last;

   always_ff @(posedge clk) begin
      if (!rst_n || clr_i)          cnt <= '0;
      else if (nak_i && cnt != SAT) cnt <= cnt + 1'b1;
   end

   assert_nak_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= SAT);
   assert_nak_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt == '0));
endmodule

// File: rtl/netdiag_status.sv
module netdiag_status
   import netdiag_pkg::*;
#(
   parameter int IDLE_CYCLES = 65600,
   parameter int NAK_THR_LO  = 4,
   parameter int NAK_THR_HI  = 128,
   parameter int ID_W        = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            rx_line,
   input  logic            evt_last_byte,
   input  logic            evt_ack,
   input  logic            ack_bcast,
   input  logic            evt_token_rx,
   input  logic [ID_W-1:0] tok_dst_a,
   input  logic [ID_W-1:0] tok_dst_b,
   input  logic [ID_W-1:0] node_id,
   input  logic            evt_response,
   input  logic            evt_token_other,
   input  logic            evt_lost_token,
   input  logic            evt_nak,
   input  logic            nak_sel,
   input  logic            cmd_tx_en,
   input  logic            cmd_tx_dis,
   input  logic            cmd_clr_flags,
   input  logic            cmd_por_clr,
   input  logic            rd_diag,
   input  logic [MSK_W-1:0] irq_mask,
   output logic [7:0]      stat_byte,
   output logic [7:0]      diag_byte,
   output logic            irq
);
   // flag index order inside the vectors below
   localparam int F_TA = 0, F_TMA = 1, F_RECON = 2, F_LOST = 3;
   localparam int F_DUP = 4, F_RXACT = 5, F_TOK = 6, F_XNAK = 7;
   localparam int NF = 8;
   localparam logic [NF-1:0] RST_PAT = NF'(1) << F_TA;

   generate
      if (ID_W < 1) begin : g_bad
         $error("ID_W must be positive");
      end
   endgenerate

   logic idle_to, nak_hit;
   logic match_now, match_q, tx_pend_q;
   logic any_clr;
   logic [NF-1:0] f_set, f_clr, f_q;

   netdiag_idle_timer #(.IDLE_CYCLES(IDLE_CYCLES)) u_idle (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .timeout_o(idle_to));

   netdiag_nak_counter #(.NAK_THR_LO(NAK_THR_LO), .NAK_THR_HI(NAK_THR_HI)) u_nak (
      .clk(clk), .rst_n(rst_n), .nak_i(evt_nak), .sel_hi_i(nak_sel),
      .clr_i(cmd_por_clr), .hit_o(nak_hit));

   assign match_now = evt_token_rx && (tok_dst_a == node_id) && (tok_dst_b == node_id);
   assign any_clr   = cmd_clr_flags || cmd_por_clr;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         match_q   <= 1'b0;
         tx_pend_q <= 1'b0;
      end else begin
         if (evt_token_rx) match_q <= match_now;
         if (cmd_tx_dis)      tx_pend_q <= 1'b0;
         else if (cmd_tx_en)  tx_pend_q <= 1'b1;
         else if (match_now)  tx_pend_q <= 1'b0;
      end
   end

   always_comb begin
      f_set = '0;
      f_clr = '0;
      f_set[F_TA]    = evt_last_byte || cmd_tx_dis;
      f_clr[F_TA]    = match_now && tx_pend_q;
      f_set[F_TMA]   = evt_ack && !ack_bcast;
      f_clr[F_TMA]   = cmd_tx_en;
      f_set[F_RECON] = idle_to;
      f_clr[F_RECON] = any_clr;
      f_set[F_LOST]  = evt_lost_token;
      f_clr[F_LOST]  = any_clr;
      f_set[F_DUP]   = evt_response && match_q;
      f_clr[F_DUP]   = rd_diag;
      f_set[F_RXACT] = rx_line;
      f_clr[F_RXACT] = any_clr;
      f_set[F_TOK]   = evt_token_other;
      f_clr[F_TOK]   = any_clr;
      f_set[F_XNAK]  = nak_hit;
      f_clr[F_XNAK]  = cmd_por_clr;
   end

   generate
      for (genvar i = 0; i < NF; i++) begin : g_flag
         netdiag_flag #(.RST_VAL(RST_PAT[i])) u_f (
            .clk(clk), .rst_n(rst_n), .set_i(f_set[i]), .clr_i(f_clr[i]), .q_o(f_q[i]));
      end
   endgenerate

   always_comb begin
      stat_byte = '0;
      stat_byte[STAT_TA]    = f_q[F_TA];
      stat_byte[STAT_TMA]   = f_q[F_TMA];
      stat_byte[STAT_RECON] = f_q[F_RECON];
      diag_byte = '0;
      diag_byte[DIAG_LOST]  = f_q[F_LOST];
      diag_byte[DIAG_DUP]   = f_q[F_DUP];
      diag_byte[DIAG_RXACT] = f_q[F_RXACT];
      diag_byte[DIAG_TOK]   = f_q[F_TOK];
      diag_byte[DIAG_XNAK]  = f_q[F_XNAK];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) irq <= 1'b0;
      else        irq <= (f_q[F_TA]    && irq_mask[MSK_TA])
                      || (f_q[F_RECON] && irq_mask[MSK_RECON])
                      || (f_q[F_XNAK]  && irq_mask[MSK_XNAK]);
   end

   assert_recon_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      stat_byte[STAT_RECON] && !any_clr |=> stat_byte[STAT_RECON]);
   assert_ta_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_last_byte || cmd_tx_dis) |=> stat_byte[STAT_TA]);
   assert_bcast_no_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !stat_byte[STAT_TMA] && !(evt_ack && !ack_bcast) |=> !stat_byte[STAT_TMA]);
   assert_dup_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_diag && !(evt_response && match_q) |=> !diag_byte[DIAG_DUP]);
   assert_xnak_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      diag_byte[DIAG_XNAK] && !cmd_por_clr |=> diag_byte[DIAG_XNAK]);
   assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_mask == '0) |=> !irq);
   assert_low_bits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      diag_byte[2:0] == 3'b000);
endmodule

// File: tb/netdiag_status_test.sv
`timescale 1ns/1ps
module netdiag_status_test;
   localparam int IDLE = 24;
   localparam int TLO  = 4;
   localparam int THI  = 128;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic rx_line = 1'b1;
   logic evt_last_byte = 0, evt_ack = 0, ack_bcast = 0, evt_token_rx = 0;
   logic [7:0] tok_dst_a = 0, tok_dst_b = 0, node_id = 8'h5A;
   logic evt_response = 0, evt_token_other = 0, evt_lost_token = 0, evt_nak = 0;
   logic nak_sel = 0, cmd_tx_en = 0, cmd_tx_dis = 0, cmd_clr_flags = 0;
   logic cmd_por_clr = 0, rd_diag = 0;
   logic [2:0] irq_mask = 0;
   logic [7:0] stat_byte, diag_byte;
   logic irq;

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // bench model state
   int  m_idle = 0, m_nak = 0;
   bit  m_ta = 1, m_tma = 0, m_recon = 0, m_lost = 0, m_dup = 0;
   bit  m_rxact = 0, m_tok = 0, m_xnak = 0, m_irq = 0, m_match = 0, m_pend = 0;

   netdiag_status #(.IDLE_CYCLES(IDLE), .NAK_THR_LO(TLO), .NAK_THR_HI(THI), .ID_W(8)) uut (
      .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .evt_last_byte(evt_last_byte),
      .evt_ack(evt_ack), .ack_bcast(ack_bcast), .evt_token_rx(evt_token_rx),
      .tok_dst_a(tok_dst_a), .tok_dst_b(tok_dst_b), .node_id(node_id),
      .evt_response(evt_response), .evt_token_other(evt_token_other),
      .evt_lost_token(evt_lost_token), .evt_nak(evt_nak), .nak_sel(nak_sel),
      .cmd_tx_en(cmd_tx_en), .cmd_tx_dis(cmd_tx_dis), .cmd_clr_flags(cmd_clr_flags),
      .cmd_por_clr(cmd_por_clr), .rd_diag(rd_diag), .irq_mask(irq_mask),
      .stat_byte(stat_byte), .diag_byte(diag_byte), .irq(irq));

   always #5 clk = ~clk;

   function automatic logic [7:0] exp_stat();
      return {5'b0, m_recon, m_tma, m_ta};
   endfunction

   function automatic logic [7:0] exp_diag();
      return {m_lost, m_dup, m_rxact, m_tok, m_xnak, 3'b000};
   endfunction

   task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic strobes_off();
      evt_last_byte = 0; evt_ack = 0; evt_token_rx = 0; evt_response = 0;
      evt_token_other = 0; evt_lost_token = 0; evt_nak = 0; cmd_tx_en = 0;
      cmd_tx_dis = 0; cmd_clr_flags = 0; cmd_por_clr = 0; rd_diag = 0;
   endtask

   // one clock: predict from requirements, advance, compare
   task automatic step();
      bit mt, to, hit, clr, nx_ta, nx_tma, nx_recon, nx_lost, nx_dup, nx_rx, nx_tok, nx_x;
      int thr;
      mt  = evt_token_rx && tok_dst_a == node_id && tok_dst_b == node_id;
      to  = !rx_line && (m_idle == IDLE - 1);
      thr = nak_sel ? THI : TLO;
      hit = evt_nak && (m_nak == thr - 1);
      clr = cmd_clr_flags || cmd_por_clr;
      nx_ta    = (evt_last_byte || cmd_tx_dis) ? 1 : (mt && m_pend) ? 0 : m_ta;
      nx_tma   = (evt_ack && !ack_bcast) ? 1 : cmd_tx_en ? 0 : m_tma;
      nx_recon = to ? 1 : clr ? 0 : m_recon;
      nx_lost  = evt_lost_token ? 1 : clr ? 0 : m_lost;
      nx_dup   = (evt_response && m_match) ? 1 : rd_diag ? 0 : m_dup;
      nx_rx    = rx_line ? 1 : clr ? 0 : m_rxact;
      nx_tok   = evt_token_other ? 1 : clr ? 0 : m_tok;
      nx_x     = hit ? 1 : cmd_por_clr ? 0 : m_xnak;
      m_irq    = (m_ta && irq_mask[0]) || (m_recon && irq_mask[1]) || (m_xnak && irq_mask[2]);
      m_idle   = (rx_line || to) ? 0 : m_idle + 1;
      if (cmd_por_clr) m_nak = 0;
      else if (evt_nak && m_nak != THI) m_nak++;
      if (evt_token_rx) m_match = mt;
      if (cmd_tx_dis) m_pend = 0; else if (cmd_tx_en) m_pend = 1; else if (mt) m_pend = 0;
      m_ta = nx_ta; m_tma = nx_tma; m_recon = nx_recon; m_lost = nx_lost;
      m_dup = nx_dup; m_rxact = nx_rx; m_tok = nx_tok; m_xnak = nx_x;
      @(posedge clk);
      #1;
      strobes_off();
      chk("status R2 R4 R5 R6", stat_byte, exp_stat());
      chk("diag R7 R8 R9", diag_byte, exp_diag());
      chk("irq R10", {7'b0, irq}, {7'b0, m_irq});
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20190));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1 stat reset", stat_byte, 8'h01);
      chk("R1 diag reset", diag_byte, 8'h00);
      chk("R1 irq reset", {7'b0, irq}, 8'h00);
      step(); // rx high -> activity
      chk("R7 rx activity bit5", diag_byte, 8'h20);
      cmd_clr_flags = 1; step();

      // R2 idle timeout, with a restart
      rx_line = 0; repeat (10) step();
      rx_line = 1; step();
      rx_line = 0; repeat (IDLE - 1) step();
      chk("R2 no recon one cycle early", {7'b0, stat_byte[2]}, 8'h00);
      step();
      chk("R2 recon at timeout", {7'b0, stat_byte[2]}, 8'h01);
      rx_line = 1;
      rd_diag = 1; step();
      chk("R3 read keeps recon", {7'b0, stat_byte[2]}, 8'h01);
      irq_mask = 3'b010; step(); step();
      chk("R10 recon irq", {7'b0, irq}, 8'h01);
      cmd_clr_flags = 1; step();
      chk("R3 clear flags clears recon", {7'b0, stat_byte[2]}, 8'h00);
      step();
      chk("R10 irq drops", {7'b0, irq}, 8'h00);
      irq_mask = 3'b000;

      // R5 / R6 transmit flags
      cmd_tx_en = 1; step();
      chk("R5 tx_en keeps TA until token", {7'b0, stat_byte[0]}, 8'h01);
      evt_token_rx = 1; tok_dst_a = 8'h5A; tok_dst_b = 8'h11; step();
      chk("R5 half match no clear", {7'b0, stat_byte[0]}, 8'h01);
      evt_token_rx = 1; tok_dst_b = 8'h5A; step();
      chk("R5 token clears TA", {7'b0, stat_byte[0]}, 8'h00);
      evt_ack = 1; ack_bcast = 1; step();
      chk("R6 broadcast ack ignored", {7'b0, stat_byte[1]}, 8'h00);
      evt_ack = 1; ack_bcast = 0; step();
      chk("R6 ack sets TMA", {7'b0, stat_byte[1]}, 8'h01);
      evt_last_byte = 1; step();
      chk("R4 last byte sets TA", {7'b0, stat_byte[0]}, 8'h01);
      cmd_tx_en = 1; step();
      chk("R5 tx_en clears TMA", {7'b0, stat_byte[1]}, 8'h00);

      // R8 duplicate id
      evt_response = 1; step();
      chk("R8 dup set after matching token", {7'b0, diag_byte[6]}, 8'h01);
      rd_diag = 1; step();
      chk("R8 read clears dup", {7'b0, diag_byte[6]}, 8'h00);

      // R11 set wins
      cmd_clr_flags = 1; evt_lost_token = 1; step();
      chk("R11 set beats clear", {7'b0, diag_byte[7]}, 8'h01);

      // R9 NAK thresholds
      nak_sel = 0;
      repeat (TLO - 1) begin evt_nak = 1; step(); end
      chk("R9 below low threshold", {7'b0, diag_byte[3]}, 8'h00);
      evt_nak = 1; step();
      chk("R9 low threshold hit", {7'b0, diag_byte[3]}, 8'h01);
      rd_diag = 1; cmd_clr_flags = 1; step();
      chk("R9 read and clear keep xnak", {7'b0, diag_byte[3]}, 8'h01);
      cmd_por_clr = 1; step();
      chk("R9 por clear", {7'b0, diag_byte[3]}, 8'h00);
      nak_sel = 1;
      repeat (THI - 1) begin evt_nak = 1; step(); end
      chk("R9 below high threshold", {7'b0, diag_byte[3]}, 8'h00);
      evt_nak = 1; step();
      chk("R9 high threshold hit", {7'b0, diag_byte[3]}, 8'h01);
      cmd_por_clr = 1; step();

      // random phase
      for (int k = 0; k < 4000; k++) begin
         if ($urandom_range(0, 29) == 0) rx_line = ~rx_line;
         evt_last_byte   = ($urandom_range(0, 19) == 0);
         evt_ack         = ($urandom_range(0, 9) == 0);
         ack_bcast       = $urandom_range(0, 1);
         evt_token_rx    = ($urandom_range(0, 7) == 0);
         tok_dst_a       = $urandom_range(0, 1) ? 8'h5A : 8'($urandom);
         tok_dst_b       = $urandom_range(0, 1) ? 8'h5A : 8'($urandom);
         evt_response    = ($urandom_range(0, 7) == 0);
         evt_token_other = ($urandom_range(0, 15) == 0);
         evt_lost_token  = ($urandom_range(0, 39) == 0);
         evt_nak         = ($urandom_range(0, 2) == 0);
         if ($urandom_range(0, 99) == 0) nak_sel = ~nak_sel;
         cmd_tx_en       = ($urandom_range(0, 15) == 0);
         cmd_tx_dis      = ($urandom_range(0, 39) == 0);
         cmd_clr_flags   = ($urandom_range(0, 29) == 0);
         cmd_por_clr     = ($urandom_range(0, 149) == 0);
         rd_diag         = ($urandom_range(0, 9) == 0);
         if ($urandom_range(0, 49) == 0) irq_mask = 3'($urandom);
         step(); // R11 random same-cycle set/clear mixes
      end

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule